// File: doc/BRIEF.md
# Accumulator Stored-Program Processor

This block is a small processor that runs a program held in its own word-addressed memory. It has one working register, the accumulator. It loops through fetching an instruction, decoding it and executing it. Every access to memory goes through an address holding register and a data holding register. A small controller decides in each cycle whether a read, a write or nothing happens on the memory.

Each instruction is one 16-bit word. It carries a 4-bit operation code and one address field that names the operand cell. The instruction set covers:
- moving words between the accumulator and memory
- wrapping arithmetic on the accumulator or on a memory cell
- a three-flag compare (greater, equal, less)
- one unconditional jump and four conditional jumps on those flags
- word input with a valid qualifier
- word output with a one-cycle strobe
- halt

A preload port writes program and data into memory. It is normally used while reset is held, before the processor starts.

Top module: `acc_cpu`

## Requirements
- R1: An instruction word keeps the opcode in bits [15:12] and the operand address in bits [11:0]. Only the low 8 bits of the address select one of 256 cells. Address bits [11:8] are ignored.
- R2: The opcodes act on the accumulator as follows, with all arithmetic wrapping modulo 2^16:
  - 0 loads memory[addr] into the accumulator.
  - 1 writes the accumulator into memory[addr].
  - 3 adds memory[addr] to the accumulator.
  - 5 subtracts memory[addr] from the accumulator.
- R3: Opcodes 2, 4 and 6 clear, increment and decrement memory[addr] in place by read-modify-write, with wrap. They leave the accumulator unchanged.
- R4: Opcode 7 compares memory[addr] with the accumulator as unsigned values. It sets exactly one of the condition flags GT (memory greater), EQ or LT. No other instruction changes the flags.
- R5: The jump opcodes load the address into the program counter when their condition holds and otherwise fall through to the next instruction:
  - 8 always jumps.
  - 9 jumps on GT.
  - 10 jumps on EQ.
  - 11 jumps on LT.
  - 12 jumps when EQ is clear.
- R6: Opcode 13 waits, with the program counter held, until in_valid is seen high at a clock edge. It then writes in_data into memory[addr].
- R7: Opcode 14 places memory[addr] on out_data and raises out_strobe for exactly one cycle. out_data holds its value until the next output.
- R8: Opcode 15 sets halted. While halted, the program counter is frozen and no further output or execution occurs.
- R9: Reset clears the program counter, the accumulator, the condition flags (all three low, so opcode 12 jumps) and halted, and drops out_strobe. Memory content survives reset, and the preload port writes memory while reset is held.
- R10: Cycle counts per instruction, counted from reset release:
  - Jumps take 4 cycles.
  - Load, store, add, subtract, compare, output and input with data ready take 5 cycles. Each cycle that input waits adds one.
  - Clear, increment and decrement take 6 cycles.
  - halted rises 4 cycles after a halt instruction begins.
- R11: A preload write in the same cycle as a processor store takes that cycle's single write port. The preload word is written and the processor's store in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload cell address |
| pre_data | input | 16 | Preload word |
| in_valid | input | 1 | Input word available |
| in_data | input | 16 | Input word |
| out_strobe | output | 1 | One-cycle pulse for a new output word |
| out_data | output | 16 | Last output word |
| halted | output | 1 | Processor has executed halt |

## Verification
Two functions can meet in one cycle: a preload write and the processor's own store, which share the memory's single write port. The bench counts cycles from reset release and raises a preload in exactly the cycle in which a store instruction commits. It does this once on the same cell and once on a different cell. It then reads both cells back with output instructions and judges them against the rule that the preload wins and the store is lost. A cycle-accurate model in the bench also compares halted, out_strobe and out_data on every clock, so the timing of stalls, strobes and halt is judged along with the values.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   typedef enum logic [3:0] {
      OP_LOAD  = 4'd0,
      OP_STORE = 4'd1,
      OP_CLEAR = 4'd2,
      OP_ADD   = 4'd3,
      OP_INC   = 4'd4,
      OP_SUB   = 4'd5,
      OP_DEC   = 4'd6,
      OP_CMP   = 4'd7,
      OP_JMP   = 4'd8,
      OP_JGT   = 4'd9,
      OP_JEQ   = 4'd10,
      OP_JLT   = 4'd11,
      OP_JNE   = 4'd12,
      OP_IN    = 4'd13,
      OP_OUT   = 4'd14,
      OP_HALT  = 4'd15
   } opcode_e;

   typedef enum logic [2:0] {
      ST_IF1, ST_IF2, ST_DEC, ST_EX1, ST_EX2, ST_EX3, ST_HALT
   } state_e;

   typedef enum logic [1:0] {
      MC_IDLE, MC_FETCH, MC_STORE
   } memcmd_e;

   localparam int FLAG_GT = 2;
   localparam int FLAG_EQ = 1;
   localparam int FLAG_LT = 0;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mar_ld,
   input  logic [AW-1:0]     mar_in,
   input  logic              mdr_ld,
   input  logic [DATA_W-1:0] mdr_in,
   input  memcmd_e           cmd,
   input  logic              pre_we,
   input  logic [AW-1:0]     pre_addr,
   input  logic [DATA_W-1:0] pre_data,
   output logic [DATA_W-1:0] mdr_q
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("acc_cpu_mem: AW out of range");
      end
   endgenerate

   logic [DATA_W-1:0] cells [DEPTH];
   logic [AW-1:0]     mar_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mar_q <= '0;
         mdr_q <= '0;
      end else begin
         if (mar_ld) mar_q <= mar_in;
         if (cmd == MC_FETCH)  mdr_q <= cells[mar_q];
         else if (mdr_ld)      mdr_q <= mdr_in;
      end
   end

   // single write port: preload has priority over the processor store
   always_ff @(posedge clk) begin
      if (pre_we)                           cells[pre_addr] <= pre_data;
      else if (rst_n && cmd == MC_STORE)    cells[mar_q]    <= mdr_q;
   end

   AST_FETCH_NOT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == MC_FETCH) |-> !mdr_ld); // R11

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit CMP_SIGNED = 1'b0
) (
   input  opcode_e           op,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opnd,
   output logic [DATA_W-1:0] res,
   output logic [2:0]        flags
);
   localparam int NCAND = 16;

   logic [DATA_W-1:0] cand [NCAND];
   logic gt, eq;

   // every candidate computed in parallel; opcode picks one
   always_comb begin
      for (int i = 0; i < NCAND; i++) cand[i] = opnd;
      cand[OP_LOAD]  = opnd;
      cand[OP_ADD]   = acc + opnd;
      cand[OP_SUB]   = acc - opnd;
      cand[OP_CLEAR] = '0;
      cand[OP_INC]   = opnd + 1'b1;
      cand[OP_DEC]   = opnd - 1'b1;
      res = cand[op];
   end

   generate
      if (CMP_SIGNED) begin : g_cmp_signed
         assign gt = $signed(opnd) > $signed(acc);
      end else begin : g_cmp_unsigned
         assign gt = opnd > acc;
      end
   endgenerate

   assign eq = (opnd == acc);

   always_comb begin
      flags          = '0;
      flags[FLAG_GT] = gt;
      flags[FLAG_EQ] = eq;
      flags[FLAG_LT] = !gt && !eq;
   end

endmodule

// File: rtl/acc_cpu_cond.sv
module acc_cpu_cond (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [2:0] flags_in,
   output logic [2:0] cond_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)  cond_q <= 3'b000;
      else if (we) cond_q <= flags_in;
   end

   AST_COND_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ($countones(cond_q) == 1)); // R4
   AST_COND_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cond_q)); // R4
   AST_COND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cond_q)); // R4

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int OP_W       = 4,
   parameter int MEM_AW     = 8,
   parameter bit CMP_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_we,
   input  logic [MEM_AW-1:0] pre_addr,
   input  logic [DATA_W-1:0] pre_data,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_strobe,
   output logic [DATA_W-1:0] out_data,
   output logic              halted
);
   localparam int FIELD_W = DATA_W - OP_W;

   generate
      if (OP_W != 4) begin : g_bad_op
         $error("acc_cpu: opcode map needs OP_W of 4");
      end
      if (MEM_AW > FIELD_W) begin : g_bad_field
         $error("acc_cpu: memory address wider than address field");
      end
   endgenerate

   state_e              state_q;
   logic [MEM_AW-1:0]   pc_q;
   opcode_e             op_q;
   logic [MEM_AW-1:0]   addr_q;
   logic [DATA_W-1:0]   acc_q;
   logic [2:0]          cond_q;

   logic                mar_ld, mdr_ld;
   logic [MEM_AW-1:0]   mar_in;
   logic [DATA_W-1:0]   mdr_in, mdr_q;
   memcmd_e             cmd;
   logic [DATA_W-1:0]   alu_res;
   logic [2:0]          alu_flags;
   logic                cond_we, take_jump;

   acc_cpu_mem #(.DATA_W(DATA_W), .AW(MEM_AW)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .mar_ld(mar_ld), .mar_in(mar_in),
      .mdr_ld(mdr_ld), .mdr_in(mdr_in), .cmd(cmd),
      .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
      .mdr_q(mdr_q)
   );

   acc_cpu_alu #(.DATA_W(DATA_W), .CMP_SIGNED(CMP_SIGNED)) u_alu (
      .op(op_q), .acc(acc_q), .opnd(mdr_q),
      .res(alu_res), .flags(alu_flags)
   );

   acc_cpu_cond u_cond (
      .clk(clk), .rst_n(rst_n), .we(cond_we),
      .flags_in(alu_flags), .cond_q(cond_q)
   );

   assign cond_we = (state_q == ST_EX2) && (op_q == OP_CMP);

   always_comb begin
      case (op_q)
         OP_JMP:  take_jump = 1'b1;
         OP_JGT:  take_jump = cond_q[FLAG_GT];
         OP_JEQ:  take_jump = cond_q[FLAG_EQ];
         OP_JLT:  take_jump = cond_q[FLAG_LT];
         OP_JNE:  take_jump = !cond_q[FLAG_EQ];
         default: take_jump = 1'b0;
      endcase
   end

   // fetch/store controller commands
   always_comb begin
      mar_ld = 1'b0;
      mar_in = pc_q;
      mdr_ld = 1'b0;
      mdr_in = acc_q;
      cmd    = MC_IDLE;
      case (state_q)
         ST_IF1: mar_ld = 1'b1;
         ST_IF2: cmd = MC_FETCH;
         ST_DEC: begin
            mar_ld = 1'b1;
            mar_in = mdr_q[MEM_AW-1:0];
         end
         ST_EX1: begin
            case (op_q)
               OP_LOAD, OP_ADD, OP_SUB, OP_CMP,
               OP_CLEAR, OP_INC, OP_DEC, OP_OUT: cmd = MC_FETCH;
               OP_STORE: mdr_ld = 1'b1;
               OP_IN: begin
                  mdr_ld = in_valid;
                  mdr_in = in_data;
               end
               default: ;
            endcase
         end
         ST_EX2: begin
            case (op_q)
               OP_STORE, OP_IN: cmd = MC_STORE;
               OP_CLEAR, OP_INC, OP_DEC: begin
                  mdr_ld = 1'b1;
                  mdr_in = alu_res;
               end
               default: ;
            endcase
         end
         ST_EX3: cmd = MC_STORE;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IF1;
         pc_q       <= '0;
         op_q       <= OP_LOAD;
         addr_q     <= '0;
         acc_q      <= '0;
         halted     <= 1'b0;
         out_strobe <= 1'b0;
         out_data   <= '0;
      end else begin
         out_strobe <= 1'b0;
         case (state_q)
            ST_IF1: state_q <= ST_IF2;
            ST_IF2: state_q <= ST_DEC;
            ST_DEC: begin
               op_q    <= opcode_e'(mdr_q[DATA_W-1 -: OP_W]);
               addr_q  <= mdr_q[MEM_AW-1:0];
               pc_q    <= pc_q + 1'b1;
               state_q <= ST_EX1;
            end
            ST_EX1: begin
               case (op_q)
                  OP_JMP, OP_JGT, OP_JEQ, OP_JLT, OP_JNE: begin
                     if (take_jump) pc_q <= addr_q;
                     state_q <= ST_IF1;
                  end
                  OP_HALT: begin
                     halted  <= 1'b1;
                     state_q <= ST_HALT;
                  end
                  OP_IN: if (in_valid) state_q <= ST_EX2;
                  default: state_q <= ST_EX2;
               endcase
            end
            ST_EX2: begin
               case (op_q)
                  OP_LOAD, OP_ADD, OP_SUB: begin
                     acc_q   <= alu_res;
                     state_q <= ST_IF1;
                  end
                  OP_OUT: begin
                     out_data   <= mdr_q;
                     out_strobe <= 1'b1;
                     state_q    <= ST_IF1;
                  end
                  OP_CLEAR, OP_INC, OP_DEC: state_q <= ST_EX3;
                  default: state_q <= ST_IF1;
               endcase
            end
            ST_EX3: state_q <= ST_IF1;
            default: state_q <= ST_HALT;
         endcase
      end
   end

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_strobe |=> !out_strobe); // R7
   AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted); // R8
   AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc_q)); // R8
   AST_HALT_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !out_strobe); // R8
   AST_IN_STALL_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EX1 && op_q == OP_IN && !in_valid) |=> $stable(pc_q)); // R6
   AST_ACC_ONLY_ON_ARITH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_CLEAR || op_q == OP_INC || op_q == OP_DEC) |=> $stable(acc_q)); // R3

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pre_we = 1'b0;
   logic [7:0]  pre_addr = '0;
   logic [15:0] pre_data = '0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        out_strobe, halted;
   logic [15:0] out_data;

   always #2 clk = ~clk;

   acc_cpu uut (
      .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
      .pre_data(pre_data), .in_valid(in_valid), .in_data(in_data),
      .out_strobe(out_strobe), .out_data(out_data), .halted(halted)
   );

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;
   logic [15:0] img [256];
   logic [15:0] got_q [$];
   logic [15:0] exp_q [$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] enc(input int op, input int a, input int junk);
      return {op[3:0], junk[3:0], a[7:0]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   // ---------------- behavioural reference model ----------------
   logic [15:0] m [256];
   logic [15:0] macc, mir, mopnd, mcap, mout;
   logic [2:0]  mcond;
   int          mpc, ph, ma, mop;
   bit          mhalt, mstrobe, mstore, started;
   logic [15:0] msval;

   always @(posedge clk) begin
      mstore = 0;
      if (!rst_n) begin
         ph = 0; mpc = 0; macc = 0; mcond = 0; mhalt = 0; mstrobe = 0; mout = 0;
         started = 1;
      end else begin
         mstrobe = 0;
         if (!mhalt) begin
            ph++;
            if (ph == 2) mir = m[mpc];
            else if (ph == 3) begin
               mpc = (mpc + 1) % 256;
               mop = int'(mir[15:12]);
               ma  = int'(mir[7:0]);
            end else if (ph == 4) begin
               if (mop >= 8 && mop <= 12) begin
                  bit t;
                  case (mop)
                     8:  t = 1;
                     9:  t = mcond[2];
                     10: t = mcond[1];
                     11: t = mcond[0];
                     default: t = !mcond[1];
                  endcase
                  if (t) mpc = ma;
                  ph = 0;
               end else if (mop == 15) mhalt = 1;
               else if (mop == 13) begin
                  if (in_valid) mcap = in_data; else ph = 3;
               end else if (mop == 1) mcap = macc;
               else mopnd = m[ma];
            end else if (ph == 5) begin
               ph = 0;
               case (mop)
                  0: macc = mopnd;
                  3: macc = macc + mopnd;
                  5: macc = macc - mopnd;
                  7: mcond = (mopnd > macc) ? 3'b100 : (mopnd == macc) ? 3'b010 : 3'b001;
                  14: begin mstrobe = 1; mout = mopnd; end
                  1, 13: begin mstore = 1; msval = mcap; end
                  2: begin mcap = 16'h0;         ph = 5; end
                  4: begin mcap = mopnd + 16'h1; ph = 5; end
                  6: begin mcap = mopnd - 16'h1; ph = 5; end
                  default: ;
               endcase
            end else if (ph == 6) begin
               mstore = 1; msval = mcap; ph = 0;
            end
         end
      end
      if (pre_we) m[pre_addr] = pre_data;
      else if (mstore) m[ma] = msval;
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (started) begin
         chk("R8 halted vs model", {31'b0, halted}, {31'b0, mhalt});
         chk("R7 strobe vs model", {31'b0, out_strobe}, {31'b0, mstrobe});
         chk("R7 out_data vs model", {16'b0, out_data}, {16'b0, mout});
         if (out_strobe) got_q.push_back(out_data);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic clear_img();
      for (int i = 0; i < 256; i++) img[i] = 16'h0;
   endtask

   task automatic boot();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         pre_we = 1'b1; pre_addr = i[7:0]; pre_data = img[i];
      end
      @(negedge clk);
      pre_we = 1'b0;
      @(negedge clk);
      chk("R9 halted low in reset", {31'b0, halted}, 32'd0);
      chk("R9 strobe low in reset", {31'b0, out_strobe}, 32'd0);
      got_q.delete();
      rst_n = 1'b1;
   endtask

   task automatic run_to_halt(input string tag, input int limit);
      int n = 0;
      while (!halted && n < limit) begin
         @(negedge clk);
         n++;
      end
      if (!halted) begin
         nchk++; nfail++;
         $display("FAIL %s watchdog actual=running expected=halted", tag);
      end
      repeat (12) @(negedge clk);
   endtask

   task automatic check_outs(input string tag);
      chk({tag, " output count"}, got_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size(); i++) begin
         if (i < got_q.size()) chk(tag, {16'b0, got_q[i]}, {16'b0, exp_q[i]});
      end
   endtask

   task automatic wait_cyc(input int c);
      while (cyc != c) @(negedge clk);
   endtask

   int halt_cyc;

   initial begin
      // Test 1: accumulator ops, wrap, junk address bits, timing
      clear_img();
      img[0]  = enc(0, 100, 10); img[1]  = enc(3, 101, 5);  img[2]  = enc(5, 102, 15);
      img[3]  = enc(1, 103, 0);  img[4]  = enc(14, 103, 3); img[5]  = enc(0, 104, 0);
      img[6]  = enc(3, 105, 0);  img[7]  = enc(1, 103, 0);  img[8]  = enc(14, 103, 0);
      img[9]  = enc(0, 106, 0);  img[10] = enc(5, 105, 0);  img[11] = enc(1, 103, 0);
      img[12] = enc(14, 103, 0); img[13] = enc(15, 0, 0);
      img[100] = 16'd5; img[101] = 16'd7; img[102] = 16'd3;
      img[104] = 16'hFFFF; img[105] = 16'd2; img[106] = 16'd0;
      boot();
      halt_cyc = -1;
      for (int n = 0; n < 500 && !halted; n++) begin
         @(negedge clk);
         if (halted) halt_cyc = cyc;
      end
      chk("R10 cycles to halted", halt_cyc, 69);
      run_to_halt("R8 test1", 100);
      exp_q = '{16'd9, 16'd1, 16'hFFFE};
      check_outs("R2 R1 accumulator results");

      // Test 2: in-place clear/increment/decrement
      clear_img();
      img[0] = enc(0, 107, 0); img[1] = enc(4, 100, 0); img[2] = enc(6, 101, 0);
      img[3] = enc(2, 102, 0); img[4] = enc(14, 100, 0); img[5] = enc(14, 101, 0);
      img[6] = enc(14, 102, 0); img[7] = enc(1, 103, 0); img[8] = enc(14, 103, 0);
      img[9] = enc(15, 0, 0);
      img[100] = 16'hFFFF; img[101] = 16'h0; img[102] = 16'h1234; img[107] = 16'h0055;
      boot();
      run_to_halt("R3 test2", 1000);
      exp_q = '{16'h0, 16'hFFFF, 16'h0, 16'h0055};
      check_outs("R3 memory rmw and acc kept");

      // Test 3: compare and every jump flavour
      clear_img();
      img[0]  = enc(0, 100, 0);  img[1]  = enc(7, 101, 9);  img[2]  = enc(11, 30, 0);
      img[3]  = enc(10, 30, 0);  img[4]  = enc(12, 6, 0);   img[5]  = enc(14, 110, 0);
      img[6]  = enc(9, 8, 0);    img[7]  = enc(14, 110, 0); img[8]  = enc(14, 111, 0);
      img[9]  = enc(7, 100, 0);  img[10] = enc(9, 30, 0);   img[11] = enc(11, 30, 0);
      img[12] = enc(12, 30, 0);  img[13] = enc(10, 15, 0);  img[14] = enc(14, 110, 0);
      img[15] = enc(14, 112, 0); img[16] = enc(7, 102, 0);  img[17] = enc(4, 120, 0);
      img[18] = enc(9, 30, 0);   img[19] = enc(10, 30, 0);  img[20] = enc(11, 22, 0);
      img[21] = enc(14, 110, 0); img[22] = enc(14, 113, 0); img[23] = enc(8, 25, 0);
      img[24] = enc(14, 110, 0); img[25] = enc(14, 120, 0); img[26] = enc(15, 0, 0);
      img[30] = enc(14, 110, 0); img[31] = enc(15, 0, 0);
      img[100] = 16'd5; img[101] = 16'd9; img[102] = 16'd3;
      img[110] = 16'h0BAD; img[111] = 16'd1; img[112] = 16'd2; img[113] = 16'd3;
      boot();
      run_to_halt("R5 test3", 2000);
      exp_q = '{16'd1, 16'd2, 16'd3, 16'd1};
      check_outs("R4 R5 compare and jumps");

      // Test 4: input stall
      clear_img();
      img[0] = enc(13, 100, 0); img[1] = enc(14, 100, 0); img[2] = enc(13, 101, 0);
      img[3] = enc(0, 101, 0);  img[4] = enc(3, 100, 0);  img[5] = enc(1, 102, 0);
      img[6] = enc(14, 102, 0); img[7] = enc(15, 0, 0);
      boot();
      wait_cyc(15);
      chk("R6 no output while waiting", got_q.size(), 0);
      wait_cyc(20);
      in_valid = 1'b1; in_data = 16'h1111;
      @(negedge clk);
      in_valid = 1'b0; in_data = 16'hDEAD;
      wait_cyc(40);
      in_valid = 1'b1; in_data = 16'h2222;
      @(negedge clk);
      in_valid = 1'b0;
      run_to_halt("R6 test4", 1000);
      exp_q = '{16'h1111, 16'h3333};
      check_outs("R6 input words");

      // Test 5: preload colliding with processor stores
      clear_img();
      img[0] = enc(0, 100, 0); img[1] = enc(1, 101, 0); img[2] = enc(1, 102, 0);
      img[3] = enc(14, 101, 0); img[4] = enc(14, 102, 0); img[5] = enc(14, 105, 0);
      img[6] = enc(15, 0, 0);
      img[100] = 16'h0042; img[102] = 16'h0009;
      boot();
      wait_cyc(9);
      pre_we = 1'b1; pre_addr = 8'd101; pre_data = 16'h7777;
      @(negedge clk);
      pre_we = 1'b0;
      wait_cyc(14);
      pre_we = 1'b1; pre_addr = 8'd105; pre_data = 16'h5555;
      @(negedge clk);
      pre_we = 1'b0;
      run_to_halt("R11 test5", 1000);
      exp_q = '{16'h7777, 16'h0009, 16'h5555};
      check_outs("R11 preload wins write port");

      // Test 6: reset clears acc and flags after test with acc nonzero
      clear_img();
      img[0] = enc(0, 100, 0); img[1] = enc(7, 102, 0); img[2] = enc(15, 0, 0);
      img[100] = 16'd5; img[102] = 16'd3;
      boot();
      run_to_halt("R9 setup", 500);
      clear_img();
      img[0] = enc(1, 103, 0); img[1] = enc(14, 103, 0); img[2] = enc(12, 4, 0);
      img[3] = enc(14, 110, 0); img[4] = enc(9, 6, 0); img[5] = enc(14, 111, 0);
      img[6] = enc(15, 0, 0);
      img[103] = 16'hABCD; img[110] = 16'h0BAD; img[111] = 16'd1;
      boot();
      run_to_halt("R9 test6", 500);
      exp_q = '{16'h0, 16'd1};
      check_outs("R9 reset acc and flags");

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      #400000;
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule